// File: doc/BRIEF.md
# Occupancy-Driven Adaptive Output Selector

This block estimates congestion on each output of a router whose channels act as elastic, distributed FIFOs, and it uses that estimate to choose an output for each packet that makes a routing decision. Downstream credits are not counted. For each output, the block keeps a counter of the flits that occupy a monitored stretch of that output's channel. A packet that is routed to an output charges that output's counter with its whole length when the decision is made. A departure strobe from the monitored stretch takes one flit off the counter.

In every cycle, up to `NUM_REQ` routing requests arrive. Each request carries a mask of admissible outputs and a packet length. The requests are resolved one after another in index order within the same cycle. Each request sees the charges made by the lower-numbered requests before it. The chosen port comes out combinationally in the cycle of the request. The counters take the effect of all charges and departures at the next clock edge.

Top module: `ols_selector`

## Requirements
- R1: After reset every occupancy counter is zero, so a request that may use every output gets port 0. With no valid request, every `grant_valid` bit is 0.
- R2: A grant names only an output whose bit is set in that request's mask. Bit `o` of the request's mask field stands for output `o`, and `grant_port` carries the output as a binary index. A request that is not valid, or that has an all-zero mask, gets no grant and charges nothing.
- R3: Among the admissible outputs, the request is granted the one with the smallest occupancy.
- R4: When several admissible outputs have the same smallest occupancy, the lowest index wins.
- R5: A granted request adds its full length field (unsigned, `LEN_W` bits; zero is allowed and adds nothing) to the chosen output's occupancy. The new value is visible from the next cycle on.
- R6: Requests in the same cycle are resolved in ascending index order. Request k compares occupancies that already include the charges of requests 0 to k-1 of that cycle.
- R7: A departure strobe on an output lowers that output's occupancy by one at the next edge.
- R8: A charge and a departure on the same output in the same cycle both take effect.
- R9: Occupancy never drops below zero. A departure on an empty output leaves the count at zero.
- R10: Occupancy saturates at 2^`CNT_W`-1, even when several charges in one cycle exceed it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | NUM_REQ | One bit per routing request |
| req_mask | input | NUM_REQ*NUM_OUT | Admissible outputs; request k uses bits [k*NUM_OUT +: NUM_OUT] |
| req_len | input | NUM_REQ*LEN_W | Packet length in flits; request k uses bits [k*LEN_W +: LEN_W] |
| depart | input | NUM_OUT | One flit left the monitored stretch of that output |
| grant_valid | output | NUM_REQ | Request k was given an output |
| grant_port | output | NUM_REQ*PORT_W | Chosen output index; request k uses bits [k*PORT_W +: PORT_W] |

## Verification
The bench builds the block with four outputs, three requests per cycle, 4-bit lengths and 5-bit counters. With these values, three maximum-length packets aimed at one output overrun the counter ceiling of 31 within a single cycle, so the saturation case can be reached in a few steps. Zero-length requests serve as probes. They reveal how two outputs' occupancies compare, through ordinary grants, without changing them. The full three-request width exercises the ordering within a cycle, including a tie that forms only after the earlier charges of the same cycle.

// File: rtl/ols_pkg.sv
package ols_pkg;

    // Width of a binary index able to name n items (at least one bit).
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Width of a running occupancy sum that cannot overflow within one cycle.
    function automatic int sum_bits(input int cnt_w, input int len_w, input int nreq);
        return ((cnt_w > len_w) ? cnt_w : len_w) + $clog2(nreq + 1) + 1;
    endfunction

endpackage

// File: rtl/ols_argmin.sv
module ols_argmin #(
    parameter int NUM_OUT = 4,
    parameter int VAL_W   = 8,
    parameter int PORT_W  = 2
) (
    input  logic [NUM_OUT*VAL_W-1:0] vals,
    input  logic [NUM_OUT-1:0]       allow,
    output logic                     found,
    output logic [PORT_W-1:0]        idx
);

    logic [VAL_W-1:0] best;

    // Linear scan; strict less-than keeps the lowest index on ties.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int o = 0; o < NUM_OUT; o++) begin
            if (allow[o] && (!found || vals[o*VAL_W +: VAL_W] < best)) begin
                found = 1'b1;
                idx   = PORT_W'(o);
                best  = vals[o*VAL_W +: VAL_W];
            end
        end
    end

endmodule

// File: rtl/ols_occ_counter.sv
module ols_occ_counter #(
    parameter int CNT_W = 6,
    parameter int SUM_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUM_W-1:0] charged,
    input  logic             dep,
    output logic [CNT_W-1:0] cnt
);

    logic [SUM_W-1:0] cap;
    logic [SUM_W-1:0] drained;
    logic [CNT_W-1:0] cnt_d;

    assign cap = SUM_W'({CNT_W{1'b1}});

    always_comb begin
        drained = (dep && charged != '0) ? charged - 1'b1 : charged;
        cnt_d   = (drained > cap) ? {CNT_W{1'b1}} : drained[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_d;
    end

    // A departure with no charge lowers a non-empty count by exactly one.
    p_dec_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (charged == SUM_W'(cnt) && dep && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

    // Nothing charged and nothing stored: stays empty whatever departs.
    p_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (charged == '0) |=> cnt == '0);

    // A total above the ceiling, even after a departure, pins the count at max.
    p_ceiling_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (charged > cap + 1'b1) |=> cnt == {CNT_W{1'b1}});

    // Charge and departure together: net change is charge minus one.
    p_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dep && charged > SUM_W'(cnt) && charged <= cap) |=> SUM_W'(cnt) == $past(charged) - 1'b1);

endmodule

// File: rtl/ols_selector.sv
module ols_selector
    import ols_pkg::*;
#(
    parameter int NUM_OUT = 4,
    parameter int NUM_REQ = 3,
    parameter int LEN_W   = 4,
    parameter int CNT_W   = 6,
    parameter int PORT_W  = idx_bits(NUM_OUT)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_REQ-1:0]        req_valid,
    input  logic [NUM_REQ*NUM_OUT-1:0] req_mask,
    input  logic [NUM_REQ*LEN_W-1:0]  req_len,
    input  logic [NUM_OUT-1:0]        depart,
    output logic [NUM_REQ-1:0]        grant_valid,
    output logic [NUM_REQ*PORT_W-1:0] grant_port
);

    localparam int SUM_W = sum_bits(CNT_W, LEN_W, NUM_REQ);

    logic [CNT_W-1:0] occ [NUM_OUT];
    // run[k][o]: occupancy of output o as seen by request k of this cycle.
    logic [SUM_W-1:0] run [NUM_REQ+1][NUM_OUT];

    genvar o, k;

    generate
        for (o = 0; o < NUM_OUT; o++) begin : g_out
            assign run[0][o] = SUM_W'(occ[o]);

            ols_occ_counter #(
                .CNT_W (CNT_W),
                .SUM_W (SUM_W)
            ) u_cnt (
                .clk     (clk),
                .rst_n   (rst_n),
                .charged (run[NUM_REQ][o]),
                .dep     (depart[o]),
                .cnt     (occ[o])
            );
        end

        for (k = 0; k < NUM_REQ; k++) begin : g_req
            logic [NUM_OUT*SUM_W-1:0] flat;
            logic [NUM_OUT-1:0]       allow;
            logic                     hit;
            logic [PORT_W-1:0]        pick;

            always_comb begin
                for (int j = 0; j < NUM_OUT; j++) flat[j*SUM_W +: SUM_W] = run[k][j];
            end

            assign allow = req_valid[k] ? req_mask[k*NUM_OUT +: NUM_OUT] : '0;

            ols_argmin #(
                .NUM_OUT (NUM_OUT),
                .VAL_W   (SUM_W),
                .PORT_W  (PORT_W)
            ) u_pick (
                .vals  (flat),
                .allow (allow),
                .found (hit),
                .idx   (pick)
            );

            assign grant_valid[k]                 = hit;
            assign grant_port[k*PORT_W +: PORT_W] = pick;

            // Charge the chosen output so later requests of this cycle see it.
            for (o = 0; o < NUM_OUT; o++) begin : g_chg
                assign run[k+1][o] = run[k][o] +
                    ((hit && pick == PORT_W'(o)) ? SUM_W'(req_len[k*LEN_W +: LEN_W]) : '0);

                // The winner is never more loaded than any other admissible output.
                p_least_r3: assert property (@(posedge clk) disable iff (!rst_n)
                    (hit && allow[o]) |-> run[k][pick] <= run[k][o]);

                // Ties resolve to the lower index.
                p_tie_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
                    (hit && allow[o] && PORT_W'(o) < pick) |-> run[k][o] > run[k][pick]);
            end

            p_grant_in_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
                hit |-> req_mask[k*NUM_OUT + int'(pick)] && req_valid[k]);

            p_no_grant_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (!req_valid[k] || req_mask[k*NUM_OUT +: NUM_OUT] == '0) |-> !hit);
        end
    endgenerate

endmodule

// File: tb/ols_selector_bench.sv
module ols_selector_bench;

    localparam int NO  = 4;
    localparam int NR  = 3;
    localparam int LW  = 4;
    localparam int CW  = 5;
    localparam int PW  = 2;
    localparam int CAP = 31;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic [NR-1:0]    req_valid = '0;
    logic [NR*NO-1:0] req_mask  = '0;
    logic [NR*LW-1:0] req_len   = '0;
    logic [NO-1:0]    depart    = '0;
    logic [NR-1:0]    grant_valid;
    logic [NR*PW-1:0] grant_port;

    int model [NO];
    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ols_selector #(
        .NUM_OUT (NO),
        .NUM_REQ (NR),
        .LEN_W   (LW),
        .CNT_W   (CW)
    ) u_ols_selector (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_mask    (req_mask),
        .req_len     (req_len),
        .depart      (depart),
        .grant_valid (grant_valid),
        .grant_port  (grant_port)
    );

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = '0; req_mask = '0; req_len = '0; depart = '0;
        foreach (model[o]) model[o] = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One cycle of stimulus; grants compared against the occupancy model.
    task automatic cycle(input logic [NR-1:0] v, input logic [NR*NO-1:0] m,
                         input logic [NR*LW-1:0] l, input logic [NO-1:0] d,
                         input string tag);
        int occ [NO];
        int best;
        int pick;
        bit got;
        @(negedge clk);
        req_valid = v; req_mask = m; req_len = l; depart = d;
        #2;
        foreach (occ[o]) occ[o] = model[o];
        for (int r = 0; r < NR; r++) begin
            got = 1'b0; best = 0; pick = 0;
            if (v[r]) begin
                for (int o = 0; o < NO; o++) begin
                    if (m[r*NO+o] && (!got || occ[o] < best)) begin
                        got = 1'b1; best = occ[o]; pick = o;
                    end
                end
            end
            checks++;
            if (grant_valid[r] !== got || (got && int'(grant_port[r*PW +: PW]) != pick)) begin
                errors++;
                $display("FAIL %s req%0d: actual valid=%0b port=%0d, expected valid=%0b port=%0d",
                         tag, r, grant_valid[r], grant_port[r*PW +: PW], got, pick);
            end
            if (got) occ[pick] += int'(l[r*LW +: LW]);
        end
        for (int o = 0; o < NO; o++) begin
            if (d[o] && occ[o] > 0) occ[o]--;
            model[o] = (occ[o] > CAP) ? CAP : occ[o];
        end
        @(negedge clk);
        req_valid = '0; req_mask = '0; req_len = '0; depart = '0;
    endtask

    task automatic t_reset_r1();
        do_reset();
        #2;
        checks++;
        if (grant_valid !== '0) begin
            errors++;
            $display("FAIL R1 idle: actual grant_valid=%b, expected 000", grant_valid);
        end
        cycle(3'b001, {4'h0, 4'h0, 4'hF}, '0, '0, "R1 all-admissible probe");
    endtask

    task automatic t_admissible_r2();
        do_reset();
        cycle(3'b011, {4'h0, 4'h0, 4'b0100}, {4'd0, 4'd0, 4'd3}, '0, "R2 single mask");
        cycle(3'b001, {4'h0, 4'h0, 4'h0}, {4'd0, 4'd0, 4'd9}, '0, "R2 empty mask");
        cycle(3'b000, {4'h0, 4'h0, 4'hF}, {4'd0, 4'd0, 4'd9}, '0, "R2 invalid request");
        cycle(3'b001, {4'h0, 4'h0, 4'b1100}, '0, '0, "R2 probe after ignored requests");
    endtask

    task automatic t_length_r5();
        do_reset();
        cycle(3'b001, {4'h0, 4'h0, 4'b0001}, {4'd0, 4'd0, 4'd5}, '0, "R5 charge port0");
        cycle(3'b001, {4'h0, 4'h0, 4'b0011}, '0, '0, "R5 probe sees length");
        cycle(3'b001, {4'h0, 4'h0, 4'b0010}, {4'd0, 4'd0, 4'd5}, '0, "R5 charge port1");
        cycle(3'b001, {4'h0, 4'h0, 4'b0011}, '0, '0, "R4 tie after equal charges");
        cycle(3'b001, {4'h0, 4'h0, 4'b1011}, {4'd0, 4'd0, 4'd7}, '0, "R3 least among three");
    endtask

    task automatic t_order_r6();
        do_reset();
        cycle(3'b111, {4'b1100, 4'b1100, 4'b1100}, {4'd3, 4'd3, 4'd3}, '0, "R6 spread within cycle");
        cycle(3'b111, {4'b1100, 4'b0110, 4'b0011}, {4'd1, 4'd2, 4'd4}, '0, "R6 mixed masks");
        cycle(3'b001, {4'h0, 4'h0, 4'hF}, '0, '0, "R3 probe after ordering");
    endtask

    task automatic t_depart_r7();
        do_reset();
        cycle(3'b011, {4'h0, 4'b1000, 4'b0100}, {4'd0, 4'd1, 4'd2}, '0, "R7 load ports 2,3");
        cycle(3'b000, '0, '0, 4'b0100, "R7 first departure");
        cycle(3'b001, {4'h0, 4'h0, 4'b1100}, '0, '0, "R7 probe tie at one");
        cycle(3'b000, '0, '0, 4'b0100, "R7 second departure");
        cycle(3'b001, {4'h0, 4'h0, 4'b1100}, '0, '0, "R7 probe drained port");
    endtask

    task automatic t_both_r8();
        do_reset();
        cycle(3'b011, {4'h0, 4'b0010, 4'b0001}, {4'd0, 4'd5, 4'd4}, '0, "R8 preload");
        cycle(3'b001, {4'h0, 4'h0, 4'b0001}, {4'd0, 4'd0, 4'd2}, 4'b0001, "R8 charge with departure");
        cycle(3'b001, {4'h0, 4'h0, 4'b0011}, '0, '0, "R8 probe tie at five");
        cycle(3'b000, '0, '0, 4'b0010, "R8 drain port1");
        cycle(3'b001, {4'h0, 4'h0, 4'b0011}, '0, '0, "R8 probe net value");
    endtask

    task automatic t_floor_r9();
        do_reset();
        cycle(3'b000, '0, '0, 4'b0001, "R9 depart while empty");
        cycle(3'b001, {4'h0, 4'h0, 4'b0010}, {4'd0, 4'd0, 4'd1}, '0, "R9 load port1");
        cycle(3'b001, {4'h0, 4'h0, 4'b0011}, '0, '0, "R9 probe stays zero");
    endtask

    task automatic t_ceiling_r10();
        do_reset();
        cycle(3'b111, {4'b0001, 4'b0001, 4'b0001}, {4'd15, 4'd15, 4'd15}, '0, "R10 overfill port0");
        cycle(3'b011, {4'h0, 4'b0010, 4'b0010}, {4'd0, 4'd15, 4'd15}, '0, "R10 load port1");
        cycle(3'b001, {4'h0, 4'h0, 4'b0011}, '0, 4'b0001, "R10 probe at ceiling");
        cycle(3'b001, {4'h0, 4'h0, 4'b0011}, '0, '0, "R10 probe after one departure");
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset_r1();
        t_admissible_r2();
        t_length_r5();
        t_order_r6();
        t_depart_r7();
        t_both_r8();
        t_floor_r9();
        t_ceiling_r10();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule